// File: doc/BRIEF.md
# Sleep Mode Sequencer with Wake Sources

This block decides when a chip leaves normal operation for one of two sleep modes and how it comes back. Software writes a two-bit mode field. Two of its encodings are ordinary run modes. The other two request sleep.

- **Standby** holds all non-retained logic in reset, gates the clocks and turns off every regulator, including the retention one.
- **Idle** does the same, except that it keeps the retention regulator on and keeps the port registers and SRAM out of reset.

The block runs on a slow clock that is always on. A divider chain, cleared only by power-on reset, derives four ticks from that clock: one per second, per minute, per hour and per day. One selectable tick can act as a wake source. A second selectable tick can drive a polling unit. The polling unit pulses an output pin and then samples the wake ports in the cycle that follows.

The wake ports are synchronized and edge-qualified per port, with an enable bit and a polarity bit. A configured wake source that switches during sleep starts a wake reset. The external active-low reset pin is held low for a minimum number of cycles and until the internal reset sources report idle. The mode field then returns to fast run.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After power-on reset the mode output is FAST (00), the reset pin is high, core and port resets are low, and clocks and both regulator enables are on.
- R2: The mode encodings are FAST=00, SLOW=01, IDLE=10 and STANDBY=11. In run, a write of FAST or SLOW updates the mode output on the next cycle and leaves every reset, clock and regulator output at its run value.
- R3: In run, a write of STANDBY makes, on the next cycle, the clock enable, main regulator enable and retention regulator enable low, and core reset and port reset high.
- R4: In run, a write of IDLE makes, on the next cycle, the clock enable and main regulator enable low, core reset high, the retention regulator enable high and port reset low.
- R5: During sleep, wake port i wakes the block only when its enable bit is 1. It then wakes on a 0-to-1 change of the synchronized input when its polarity bit is 1, or on a 1-to-0 change when its polarity bit is 0. A disabled port, or a change in the opposite direction, leaves the block asleep.
- R6: A wake drives the reset pin low for at least MIN_RST slow cycles. With the internal-busy input low it is exactly MIN_RST cycles. Otherwise the pin is released on the first cycle after busy is seen low with the minimum already met.
- R7: While the reset pin is low, core reset is high. Port reset is low when the wake leaves idle and high when it leaves standby.
- R8: When the reset pin rises, the mode output is FAST and clock and regulator enables are on.
- R9: Mode writes made while asleep or in wake reset leave the mode output unchanged.
- R10: With polling enabled, the poll pin pulses for one cycle on each selected tick. Wake ports are sampled at the end of that pulse cycle, so a qualifying change wakes the block with the reset pin falling two cycles after the pulse.
- R11: Tick select codes 0, 1, 2 and 3 choose the second, minute, hour and day ticks for both the wake tick and the poll tick. When the tick wake enable is set, the selected tick wakes the block.
- R12: The tick chain is cleared only by power-on reset, so tick phase runs on unchanged through sleep and wake reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mode_wr_en | input | 1 | Mode field write strobe |
| mode_wr_data | input | 2 | Mode value written |
| mode_o | output | 2 | Current mode field |
| wake_tick_sel | input | 2 | Tick used as wake source |
| rtc_wake_en | input | 1 | Enables the tick as a wake source |
| poll_en | input | 1 | Enables polled sampling of the wake ports |
| poll_tick_sel | input | 2 | Tick driving the polling unit |
| port_en | input | N_PORTS | Per-port wake enable |
| port_pol | input | N_PORTS | Per-port edge polarity, 1 = rising |
| wake_port_i | input | N_PORTS | Asynchronous wake port inputs |
| poll_pulse_o | output | 1 | Polling strobe pin |
| int_rst_busy | input | 1 | Some internal reset source still active |
| rst_pin_n | output | 1 | External reset pin, active low |
| core_rst | output | 1 | Reset to non-retained logic |
| port_rst | output | 1 | Reset to port registers and SRAM |
| clk_run_en | output | 1 | Functional clock enable |
| main_reg_en | output | 1 | Main regulator enable |
| aux_reg_en | output | 1 | Retention regulator enable |

## Verification
The wake function is tried with several port patterns:

- a change on a disabled port;
- a change opposite to the programmed polarity;
- rising and falling changes that qualify;
- the same change seen through the polling sampler.

Together these separate the enable gate, the polarity choice and the timing of the polled capture. Wakes from idle and from standby are compared to tell the two reset scopes apart. A wake with the busy input held shows that the pin waits beyond the minimum. Tick-driven wakes and poll intervals at every select code check the divider taps. Poll pulses are recorded across a wake reset to show that the tick phase is untouched.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;
   typedef enum logic [1:0] {
      MODE_FAST = 2'b00,
      MODE_SLOW = 2'b01,
      MODE_IDLE = 2'b10,
      MODE_STBY = 2'b11
   } lp_mode_e;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_WRST  = 2'd2
   } lp_state_e;

   localparam int N_TAPS = 4;
endpackage

// File: rtl/lpm_rtc_chain.sv
`timescale 1ns/1ps
module lpm_rtc_chain import lpm_pkg::*; #(
   parameter int TICKS_PER_SEC = 32768,
   parameter int SEC_PER_MIN   = 60,
   parameter int MIN_PER_HOUR  = 60,
   parameter int HOUR_PER_DAY  = 24
) (
   input  logic              clk,
   input  logic              por_n,
   output logic [N_TAPS-1:0] tap_o
);
   localparam int PRE_W = $clog2(TICKS_PER_SEC);
   localparam int MAXM  = (SEC_PER_MIN > MIN_PER_HOUR) ?
                          ((SEC_PER_MIN > HOUR_PER_DAY) ? SEC_PER_MIN : HOUR_PER_DAY) :
                          ((MIN_PER_HOUR > HOUR_PER_DAY) ? MIN_PER_HOUR : HOUR_PER_DAY);
   localparam int MOD_W = $clog2(MAXM) + 1;

   if (TICKS_PER_SEC < 2) begin : g_bad_pre
      $error("TICKS_PER_SEC must be at least 2");
   end
   if (SEC_PER_MIN < 1 || MIN_PER_HOUR < 1 || HOUR_PER_DAY < 1) begin : g_bad_mod
      $error("tick chain moduli must be positive");
   end

   logic [PRE_W-1:0] pre_q;

   // cleared by power-on reset only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) pre_q <= '0;
      else if (pre_q == PRE_W'(TICKS_PER_SEC - 1)) pre_q <= '0;
      else pre_q <= pre_q + 1'b1;
   end

   assign tap_o[0] = (pre_q == PRE_W'(TICKS_PER_SEC - 1));

   for (genvar g = 1; g < N_TAPS; g++) begin : g_stage
      localparam int M = (g == 1) ? SEC_PER_MIN : ((g == 2) ? MIN_PER_HOUR : HOUR_PER_DAY);
      logic [MOD_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) cnt_q <= '0;
         else if (tap_o[g-1]) begin
            if (cnt_q == MOD_W'(M - 1)) cnt_q <= '0;
            else cnt_q <= cnt_q + 1'b1;
         end
      end
      assign tap_o[g] = tap_o[g-1] && (cnt_q == MOD_W'(M - 1));
   end

   // R11
   sec_tick_single_chk: assert property (@(posedge clk) disable iff (!por_n)
      tap_o[0] |=> !tap_o[0]);
endmodule

// File: rtl/lpm_wake_detect.sv
`timescale 1ns/1ps
module lpm_wake_detect #(
   parameter int N_PORTS      = 4,
   parameter bit POLL_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic [N_PORTS-1:0] port_i,
   input  logic [N_PORTS-1:0] port_en,
   input  logic [N_PORTS-1:0] port_pol,
   input  logic               poll_en,
   input  logic               poll_tick,
   output logic               poll_pulse_o,
   output logic               edge_o
);
   if (N_PORTS < 1) begin : g_bad_ports
      $error("N_PORTS must be at least 1");
   end

   logic [N_PORTS-1:0] sync1_q, sync2_q, samp_q, samp_d1_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sync1_q   <= '0;
         sync2_q   <= '0;
         samp_d1_q <= '0;
      end else begin
         sync1_q   <= port_i;
         sync2_q   <= sync1_q;
         samp_d1_q <= samp_q;
      end
   end

   if (POLL_SUPPORT) begin : g_poll
      logic pulse_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            pulse_q <= 1'b0;
            samp_q  <= '0;
         end else begin
            pulse_q <= poll_en && poll_tick;
            if (!poll_en || pulse_q) samp_q <= sync2_q;
         end
      end
      assign poll_pulse_o = pulse_q;

      // R10
      poll_capture_chk: assert property (@(posedge clk) disable iff (!por_n)
         ($past(poll_en) && !$stable(samp_q)) |-> $past(pulse_q));
   end else begin : g_direct
      logic unused_poll;
      assign unused_poll = poll_en ^ poll_tick;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) samp_q <= '0;
         else samp_q <= sync2_q;
      end
      assign poll_pulse_o = 1'b0;
   end

   logic [N_PORTS-1:0] rise, fall;
   assign rise   = samp_q & ~samp_d1_q;
   assign fall   = ~samp_q & samp_d1_q;
   assign edge_o = |(port_en & ((port_pol & rise) | (~port_pol & fall)));
endmodule

// File: rtl/lpm_seq.sv
`timescale 1ns/1ps
module lpm_seq import lpm_pkg::*; #(
   parameter int MIN_RST = 4
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       wr_en,
   input  logic [1:0] wr_data,
   input  logic       wake,
   input  logic       int_rst_busy,
   output logic [1:0] mode_o,
   output logic       rst_pin_n,
   output logic       core_rst,
   output logic       port_rst,
   output logic       clk_run_en,
   output logic       main_reg_en,
   output logic       aux_reg_en
);
   localparam int CW = $clog2(MIN_RST + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(MIN_RST - 1);

   if (MIN_RST < 1) begin : g_bad_min
      $error("MIN_RST must be at least 1");
   end

   lp_state_e state_q;
   lp_mode_e  mode_q;
   logic      stby_q;
   logic [CW-1:0] cnt_q;
   logic      wr_sleep;

   assign wr_sleep = wr_en && (wr_data == MODE_IDLE || wr_data == MODE_STBY);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q <= ST_RUN;
         mode_q  <= MODE_FAST;
         stby_q  <= 1'b0;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (wr_en) mode_q <= lp_mode_e'(wr_data);
               if (wr_sleep) begin
                  state_q <= ST_SLEEP;
                  stby_q  <= (wr_data == MODE_STBY);
               end
            end
            ST_SLEEP: begin
               if (wake) begin
                  state_q <= ST_WRST;
                  cnt_q   <= '0;
               end
            end
            ST_WRST: begin
               if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
               else if (!int_rst_busy) begin
                  state_q <= ST_RUN;
                  mode_q  <= MODE_FAST;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign mode_o      = mode_q;
   assign rst_pin_n   = (state_q != ST_WRST);
   assign core_rst    = (state_q != ST_RUN);
   assign port_rst    = (state_q != ST_RUN) && stby_q;
   assign clk_run_en  = (state_q != ST_SLEEP);
   assign main_reg_en = (state_q != ST_SLEEP);
   assign aux_reg_en  = !((state_q == ST_SLEEP) && stby_q);

   // consecutive low cycles of the pin, for the minimum-width check
   logic [CW-1:0] low_run_q;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) low_run_q <= '0;
      else if (rst_pin_n) low_run_q <= '0;
      else if (low_run_q != CW'(MIN_RST)) low_run_q <= low_run_q + 1'b1;
   end

   // R3
   stby_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == ST_RUN && wr_en && wr_data == MODE_STBY)
      |=> (!main_reg_en && !aux_reg_en && port_rst && !clk_run_en));
   // R4
   idle_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == ST_RUN && wr_en && wr_data == MODE_IDLE)
      |=> (!main_reg_en && aux_reg_en && !port_rst && core_rst));
   // R6
   rst_width_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_pin_n) |-> (low_run_q == CW'(MIN_RST)));
   // R8
   fast_after_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_pin_n) |-> (mode_o == MODE_FAST && main_reg_en && clk_run_en));
   // R9
   sleep_mode_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (state_q == ST_SLEEP) |=> $stable(mode_o));
endmodule

// File: rtl/lpm_wake_ctrl.sv
`timescale 1ns/1ps
module lpm_wake_ctrl import lpm_pkg::*; #(
   parameter int N_PORTS       = 4,
   parameter int TICKS_PER_SEC = 32768,
   parameter int SEC_PER_MIN   = 60,
   parameter int MIN_PER_HOUR  = 60,
   parameter int HOUR_PER_DAY  = 24,
   parameter int MIN_RST       = 4,
   parameter bit POLL_SUPPORT  = 1'b1
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               mode_wr_en,
   input  logic [1:0]         mode_wr_data,
   output logic [1:0]         mode_o,
   input  logic [1:0]         wake_tick_sel,
   input  logic               rtc_wake_en,
   input  logic               poll_en,
   input  logic [1:0]         poll_tick_sel,
   input  logic [N_PORTS-1:0] port_en,
   input  logic [N_PORTS-1:0] port_pol,
   input  logic [N_PORTS-1:0] wake_port_i,
   output logic               poll_pulse_o,
   input  logic               int_rst_busy,
   output logic               rst_pin_n,
   output logic               core_rst,
   output logic               port_rst,
   output logic               clk_run_en,
   output logic               main_reg_en,
   output logic               aux_reg_en
);
   logic [N_TAPS-1:0] taps;
   logic wake_tick, poll_tick, port_edge, wake;

   lpm_rtc_chain #(
      .TICKS_PER_SEC(TICKS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN),
      .MIN_PER_HOUR(MIN_PER_HOUR),   .HOUR_PER_DAY(HOUR_PER_DAY)
   ) u_rtc (
      .clk(clk), .por_n(por_n), .tap_o(taps)
   );

   assign wake_tick = taps[wake_tick_sel];
   assign poll_tick = taps[poll_tick_sel];

   lpm_wake_detect #(.N_PORTS(N_PORTS), .POLL_SUPPORT(POLL_SUPPORT)) u_det (
      .clk(clk), .por_n(por_n), .port_i(wake_port_i), .port_en(port_en),
      .port_pol(port_pol), .poll_en(poll_en), .poll_tick(poll_tick),
      .poll_pulse_o(poll_pulse_o), .edge_o(port_edge)
   );

   assign wake = port_edge || (rtc_wake_en && wake_tick);

   lpm_seq #(.MIN_RST(MIN_RST)) u_seq (
      .clk(clk), .por_n(por_n), .wr_en(mode_wr_en), .wr_data(mode_wr_data),
      .wake(wake), .int_rst_busy(int_rst_busy), .mode_o(mode_o),
      .rst_pin_n(rst_pin_n), .core_rst(core_rst), .port_rst(port_rst),
      .clk_run_en(clk_run_en), .main_reg_en(main_reg_en), .aux_reg_en(aux_reg_en)
   );

   // R7
   wake_scope_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_pin_n |-> (core_rst && main_reg_en && aux_reg_en));
endmodule

// File: tb/sim_lpm_wake_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_wake_ctrl;
   localparam int NP = 4;
   localparam int TPS = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic mode_wr_en = 1'b0;
   logic [1:0] mode_wr_data = 2'b00;
   logic [1:0] mode_o;
   logic [1:0] wake_tick_sel = 2'd0;
   logic rtc_wake_en = 1'b0;
   logic poll_en = 1'b0;
   logic [1:0] poll_tick_sel = 2'd0;
   logic [NP-1:0] port_en = '0, port_pol = '0, wake_port_i = '0;
   logic poll_pulse_o, int_rst_busy = 1'b0;
   logic rst_pin_n, core_rst, port_rst, clk_run_en, main_reg_en, aux_reg_en;

   always #5 clk = ~clk;

   lpm_wake_ctrl #(
      .N_PORTS(NP), .TICKS_PER_SEC(TPS), .SEC_PER_MIN(3), .MIN_PER_HOUR(2),
      .HOUR_PER_DAY(2), .MIN_RST(4), .POLL_SUPPORT(1'b1)
   ) u0 (.*);

   int checks = 0, failures = 0;
   bit done = 1'b0;

   typedef struct { int low; bit prst; } exp_t;
   exp_t exp_q[$];
   time pulse_t[$];
   time last_pulse_t = 0, fall_t = 0, pulse_before_fall_t = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: scoreboard of wake resets and record of poll pulses
   int  lowc = 0;
   bit  was_low = 1'b0, seen_prst = 1'b0, core_ok = 1'b1;
   always @(negedge clk) begin
      if (por_n) begin
         if (poll_pulse_o) begin
            last_pulse_t = $time;
            pulse_t.push_back($time);
         end
         if (!rst_pin_n) begin
            if (!was_low) begin
               fall_t = $time;
               pulse_before_fall_t = last_pulse_t;
            end
            lowc++;
            if (port_rst) seen_prst = 1'b1;
            if (!core_rst) core_ok = 1'b0;
         end else if (was_low) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5", "unexpected wake reset", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               // R6 width of the reset pin pulse
               chk(lowc == e.low, "R6", "reset pin low cycles", lowc, e.low);
               // R7 reset scope during wake reset
               chk(seen_prst == e.prst && core_ok, "R7", "port reset during wake",
                   int'(seen_prst), int'(e.prst));
               // R8 state after release
               chk(mode_o == 2'b00 && main_reg_en && clk_run_en && aux_reg_en, "R8",
                   "mode after wake", int'(mode_o), 0);
            end
            lowc = 0; seen_prst = 1'b0; core_ok = 1'b1;
         end
         was_low = !rst_pin_n;
      end
   end

   task automatic wr(input logic [1:0] m);
      @(negedge clk); mode_wr_en = 1'b1; mode_wr_data = m;
      @(negedge clk); mode_wr_en = 1'b0;
   endtask

   task automatic push(input int low, input bit prst);
      exp_t e;
      e.low = low; e.prst = prst;
      exp_q.push_back(e);
   endtask

   task automatic wait_done(input string req);
      int k = 0;
      while (exp_q.size() != 0 && k < 400) begin
         @(negedge clk); k++;
      end
      chk(exp_q.size() == 0, req, "expected wake completed", exp_q.size(), 0);
   endtask

   task automatic measure_poll(input logic [1:0] sel, input int expc);
      int n = 0;
      poll_tick_sel = sel; poll_en = 1'b1;
      @(negedge clk);
      while (!poll_pulse_o) @(negedge clk);
      @(negedge clk); n = 1;
      while (!poll_pulse_o && n < 200) begin @(negedge clk); n++; end
      // R11 tap period per select code
      chk(n == expc, "R11", $sformatf("poll interval sel=%0d", sel), n, expc);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mode_o == 2'b00 && rst_pin_n && !core_rst && !port_rst && clk_run_en &&
          main_reg_en && aux_reg_en && !poll_pulse_o, "R1", "reset state", int'(mode_o), 0);

      // R2 run mode writes
      wr(2'b01);
      chk(mode_o == 2'b01 && main_reg_en && !core_rst && clk_run_en, "R2", "SLOW write", int'(mode_o), 1);
      wr(2'b00);
      chk(mode_o == 2'b00 && main_reg_en && !core_rst, "R2", "FAST write", int'(mode_o), 0);

      // R4 idle entry, port 0 rising
      port_en = 4'b0001; port_pol = 4'b0001;
      repeat (4) @(negedge clk);
      wr(2'b10);
      chk(!main_reg_en && aux_reg_en && !clk_run_en && core_rst && !port_rst && mode_o == 2'b10,
          "R4", "idle outputs", int'(aux_reg_en), 1);
      // R9 write while asleep
      wr(2'b11);
      chk(mode_o == 2'b10 && aux_reg_en, "R9", "mode write ignored in sleep", int'(mode_o), 2);
      // R5 disabled port change
      wake_port_i[1] = 1'b1;
      repeat (8) @(negedge clk);
      chk(rst_pin_n && !main_reg_en, "R5", "disabled port keeps sleep", int'(main_reg_en), 0);
      push(4, 1'b0);
      wake_port_i[0] = 1'b1;
      wait_done("R5");

      // R3 standby entry, port 0 falling, port 2 rising
      port_en = 4'b0101; port_pol = 4'b0100;
      wake_port_i[2] = 1'b1;
      repeat (6) @(negedge clk);
      wr(2'b11);
      chk(!main_reg_en && !aux_reg_en && !clk_run_en && core_rst && port_rst && mode_o == 2'b11,
          "R3", "standby outputs", int'(port_rst), 1);
      wake_port_i[2] = 1'b0;
      repeat (8) @(negedge clk);
      chk(rst_pin_n && !main_reg_en, "R5", "opposite edge keeps sleep", int'(main_reg_en), 0);
      push(4, 1'b1);
      wake_port_i[0] = 1'b0;
      wait_done("R5");

      // R6 busy extends the wake reset
      port_en = 4'b0001; port_pol = 4'b0001;
      int_rst_busy = 1'b1;
      repeat (4) @(negedge clk);
      wr(2'b10);
      push(7, 1'b0);
      wake_port_i[0] = 1'b1;
      begin
         int k = 0;
         while (rst_pin_n && k < 50) begin @(negedge clk); k++; end
      end
      repeat (6) @(negedge clk);
      int_rst_busy = 1'b0;
      wait_done("R6");

      // R10 polled wake, port 0 falling, poll on minute tick
      port_pol = 4'b0000;
      poll_tick_sel = 2'd1; poll_en = 1'b1;
      repeat (4) @(negedge clk);
      wr(2'b10);
      @(negedge clk);
      while (!poll_pulse_o) @(negedge clk);
      repeat (2) @(negedge clk);
      begin
         time chg_t;
         chg_t = $time;
         push(4, 1'b0);
         wake_port_i[0] = 1'b0;
         wait_done("R10");
         chk(pulse_before_fall_t > chg_t, "R10", "wake waited for poll", 1, 1);
         chk(fall_t - pulse_before_fall_t == 20, "R10", "fall after pulse ns",
             int'(fall_t - pulse_before_fall_t), 20);
      end

      // R11 poll interval for each tap
      port_en = '0;
      measure_poll(2'd0, TPS);
      measure_poll(2'd1, TPS * 3);
      measure_poll(2'd2, TPS * 6);
      measure_poll(2'd3, TPS * 12);

      // R11 tick wake, R12 tick phase kept across the wake reset
      poll_tick_sel = 2'd0;
      @(negedge clk);
      while (!poll_pulse_o) @(negedge clk);
      begin
         time t0;
         int bad = 0, cnt = 0;
         t0 = $time;
         pulse_t.delete();
         rtc_wake_en = 1'b1; wake_tick_sel = 2'd0;
         wr(2'b10);
         push(4, 1'b0);
         wait_done("R11");
         rtc_wake_en = 1'b0;
         repeat (12) @(negedge clk);
         foreach (pulse_t[i]) begin
            cnt++;
            if (((pulse_t[i] - t0) % (TPS * 10)) != 0) bad++;
         end
         // R12
         chk(bad == 0 && cnt >= 4, "R12", "poll pulses misaligned after wake", bad, 0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule